// File: doc/BRIEF.md
# Filtered Reset Generator with Watchdog Routing

This block drives the active-low internal reset that holds the core and peripherals. It has two sources. The first is an external active-low reset pin. The pin is brought into the main clock domain by a synchronizer chain. The synchronized level must then stay low for a run of consecutive samples before it counts as a reset request. A shorter low pulse is treated as noise. When the pin returns high, the reset stays asserted for a stabilization wait and then releases.

The second source is a watchdog timeout. A routing bit decides where a timeout goes. When the bit is 1, the timeout resets the chip. When it is 0, the timeout becomes a one-cycle non-maskable interrupt request. The routing bit is written through a small strobe-and-value pair. Any internal reset clears it to 0. The watchdog path therefore cannot stand in for a power-on reset: software has to set the bit again after every reset. A watchdog-triggered reset uses the same stabilization wait before it releases.

Top module: `rstgen_top`

## Requirements
- R1: `int_rst_n` is active low: 0 holds the chip in reset and 1 lets it run. After the pin has been low from power-up, `int_rst_n` is 0 and `nmi_req` is 0.
- R2: The pin passes through a synchronizer of SYNC_STAGES flops (default 2) and then needs LOW_SAMPLES consecutive low samples (default 3). With the defaults, a pin driven low just after edge N makes `int_rst_n` fall at edge N+6.
- R3: A pin low pulse that is shorter than LOW_SAMPLES sampled cycles has no effect. A 2-cycle pulse leaves `int_rst_n` at 1.
- R4: After a pin reset, if the pin is driven high just after edge M, `int_rst_n` rises at edge M+3+STAB_CYCLES and stays 0 until then.
- R5: Any synchronized low sample during the stabilization wait clears the wait count. The count restarts at the next high sample, so the release moves later. A valid low run asserts the reset hold again.
- R6: When the routing bit is 1, a watchdog timeout sampled at edge T pulls `int_rst_n` to 0 at edge T. The reset releases at edge T+STAB_CYCLES.
- R7: When the routing bit is 0, a watchdog timeout sampled at edge T sets `nmi_req` to 1 for exactly the cycle after edge T. `int_rst_n` is unchanged.
- R8: Only the rising edge of `wdt_timeout` counts as a timeout. Holding it high for several cycles gives a single NMI pulse.
- R9: `cfg_wr` with `cfg_route_rst` sets the routing bit, which takes effect from the next edge. Any internal reset clears the routing bit, and a write made while `int_rst_n` is 0 is ignored.
- R10: No NMI pulse is produced while `int_rst_n` is 0, or in the cycle where a pin reset request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock; the pin is sampled only on its rising edges |
| ext_rst_n | input | 1 | Raw external reset pin, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog timeout, synchronous to clk; its rising edge is one event |
| cfg_wr | input | 1 | Write strobe for the routing bit |
| cfg_route_rst | input | 1 | Routing value: 1 = timeout resets, 0 = timeout raises NMI |
| int_rst_n | output | 1 | Internal reset, active low, registered |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The assertions take for granted that `wdt_timeout`, `cfg_wr` and `cfg_route_rst` are synchronous to `clk`. They also assume the clock runs from power-up while the pin is held low, so the reset hold is established before the watchdog path is ever used. The bench drives every input at the falling edge. It holds the pin low from time zero, and it pulses the watchdog only when the routing bit's value follows from its own earlier writes and resets. This lets every expected edge be predicted from the cycle counts stated in the requirements.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

   typedef enum logic {
      WD_TO_NMI   = 1'b0,
      WD_TO_RESET = 1'b1
   } wd_route_e;

   // counter width able to hold the value n
   function automatic int cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstgen_sync: STAGES must be at least 2");
   end

   logic chain [STAGES];

   always_ff @(posedge clk) chain[0] <= din;

   for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) chain[gi] <= chain[gi-1];
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/rstgen_lowfilt.sv
module rstgen_lowfilt
   import rstgen_pkg::*;
#(
   parameter int LOW_SAMPLES = 3
) (
   input  logic clk,
   input  logic pin_s,
   output logic pin_req
);
   if (LOW_SAMPLES < 1) begin : g_bad_low
      $error("rstgen_lowfilt: LOW_SAMPLES must be at least 1");
   end

   localparam int            W   = cnt_w(LOW_SAMPLES);
   localparam logic [W-1:0]  LIM = W'(LOW_SAMPLES);

   logic [W-1:0] run_q;

   // one high sample clears the run, lows saturate at the limit
   always_ff @(posedge clk) begin
      if (pin_s)
         run_q <= '0;
      else if (run_q != LIM)
         run_q <= run_q + W'(1);
   end

   assign pin_req = (run_q == LIM);
endmodule

// File: rtl/rstgen_hold.sv
module rstgen_hold
   import rstgen_pkg::*;
#(
   parameter int STAB_CYCLES = 1024
) (
   input  logic clk,
   input  logic pin_s,
   input  logic pin_req,
   input  logic wd_req,
   output logic in_reset
);
   if (STAB_CYCLES < 1) begin : g_bad_stab
      $error("rstgen_hold: STAB_CYCLES must be at least 1");
   end

   localparam int           W    = cnt_w(STAB_CYCLES);
   localparam logic [W-1:0] LAST = W'(STAB_CYCLES - 1);

   logic [W-1:0] wait_q;
   logic         hold_q;

   always_ff @(posedge clk) begin
      if (pin_req || wd_req) begin
         hold_q <= 1'b1;
         wait_q <= '0;
      end else if (hold_q) begin
         if (!pin_s)
            wait_q <= '0;
         else if (wait_q == LAST) begin
            hold_q <= 1'b0;
            wait_q <= '0;
         end else
            wait_q <= wait_q + W'(1);
      end
   end

   assign in_reset = hold_q;

   // R4: the hold only releases after a high pin sample
   assert_release_pin_high_R4: assert property (@(posedge clk)
      $fell(hold_q) |-> $past(pin_s));
endmodule

// File: rtl/rstgen_wdroute.sv
module rstgen_wdroute
   import rstgen_pkg::*;
(
   input  logic clk,
   input  logic in_reset,
   input  logic pin_req,
   input  logic wd_to,
   input  logic cfg_wr,
   input  logic cfg_route_rst,
   output logic wd_req,
   output logic route_rst,
   output logic nmi_q
);
   wd_route_e route_q;
   logic      wd_prev_q;
   logic      rise;

   always_ff @(posedge clk) begin
      wd_prev_q <= wd_to;
      if (in_reset)
         route_q <= WD_TO_NMI;
      else if (cfg_wr)
         route_q <= wd_route_e'(cfg_route_rst);
   end

   assign rise      = wd_to & ~wd_prev_q;
   assign route_rst = (route_q == WD_TO_RESET);
   assign wd_req    = rise && route_rst && !in_reset;

   always_ff @(posedge clk)
      nmi_q <= rise && !route_rst && !in_reset && !pin_req;

   // R8: a request is never two cycles long
   assert_nmi_single_R8: assert property (@(posedge clk) disable iff (in_reset)
      nmi_q |=> !nmi_q);
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top #(
   parameter int SYNC_STAGES = 2,
   parameter int LOW_SAMPLES = 3,
   parameter int STAB_CYCLES = 1024
) (
   input  logic clk,
   input  logic ext_rst_n,
   input  logic wdt_timeout,
   input  logic cfg_wr,
   input  logic cfg_route_rst,
   output logic int_rst_n,
   output logic nmi_req
);
   logic pin_s;
   logic pin_req;
   logic wd_req;
   logic in_reset;
   logic route_rst;
   logic wd_prev;

   rstgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .din  (ext_rst_n),
      .dout (pin_s)
   );

   rstgen_lowfilt #(.LOW_SAMPLES(LOW_SAMPLES)) u_filt (
      .clk     (clk),
      .pin_s   (pin_s),
      .pin_req (pin_req)
   );

   rstgen_hold #(.STAB_CYCLES(STAB_CYCLES)) u_hold (
      .clk      (clk),
      .pin_s    (pin_s),
      .pin_req  (pin_req),
      .wd_req   (wd_req),
      .in_reset (in_reset)
   );

   rstgen_wdroute u_route (
      .clk           (clk),
      .in_reset      (in_reset),
      .pin_req       (pin_req),
      .wd_to         (wdt_timeout),
      .cfg_wr        (cfg_wr),
      .cfg_route_rst (cfg_route_rst),
      .wd_req        (wd_req),
      .route_rst     (route_rst),
      .nmi_q         (nmi_req)
   );

   assign int_rst_n = ~in_reset;

   always_ff @(posedge clk) wd_prev <= wdt_timeout;

   // R2: a filtered pin request puts the chip in reset on the next edge
   assert_pin_req_resets_R2: assert property (@(posedge clk) disable iff (!int_rst_n)
      pin_req |=> !int_rst_n);

   // R6: a timeout routed to reset pulls the reset low
   assert_wdt_reset_R6: assert property (@(posedge clk) disable iff (!int_rst_n)
      (wdt_timeout && !wd_prev && route_rst) |=> !int_rst_n);

   // R7: a timeout routed to NMI raises the request
   assert_wdt_nmi_R7: assert property (@(posedge clk) disable iff (!int_rst_n)
      (wdt_timeout && !wd_prev && !route_rst && !pin_req) |=> nmi_req);

   // R10: no request while the chip is in reset
   assert_no_nmi_in_reset_R10: assert property (@(posedge clk) disable iff (1'b0)
      !int_rst_n |-> !nmi_req);
endmodule

// File: tb/tb_rstgen_top.sv
module tb_rstgen_top;
   localparam int STAB  = 32;
   localparam int LIMIT = 200000;

   logic clk = 1'b0;
   logic ext_rst_n = 1'b0;
   logic wdt_timeout = 1'b0;
   logic cfg_wr = 1'b0;
   logic cfg_route_rst = 1'b0;
   logic int_rst_n;
   logic nmi_req;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int    at;
      logic  rst_n;
      logic  nmi;
      string tag;
   } exp_t;
   exp_t sb[$];

   rstgen_top #(.SYNC_STAGES(2), .LOW_SAMPLES(3), .STAB_CYCLES(STAB)) dut (
      .clk           (clk),
      .ext_rst_n     (ext_rst_n),
      .wdt_timeout   (wdt_timeout),
      .cfg_wr        (cfg_wr),
      .cfg_route_rst (cfg_route_rst),
      .int_rst_n     (int_rst_n),
      .nmi_req       (nmi_req)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > LIMIT && !done) begin
         done = 1'b1;
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // scoreboard monitor: pop every item due in this cycle
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].at == cyc) begin
            checks = checks + 1;
            if (int_rst_n !== sb[i].rst_n || nmi_req !== sb[i].nmi) begin
               errors = errors + 1;
               $display("FAIL %s cycle %0d: actual rst_n=%b nmi=%b expected rst_n=%b nmi=%b",
                        sb[i].tag, cyc, int_rst_n, nmi_req, sb[i].rst_n, sb[i].nmi);
            end
            sb.delete(i);
         end
      end
   end

   task automatic expect_at(input int off, input logic r, input logic n, input string tag);
      exp_t e;
      e.at = cyc + off;
      e.rst_n = r;
      e.nmi = n;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      tick(1);
      // R1: pin low since power-up gives the reset state
      expect_at(8, 1'b0, 1'b0, "R1");
      tick(10);

      // R10 and R9: timeout and routing write during reset
      wdt_timeout = 1'b1; cfg_wr = 1'b1; cfg_route_rst = 1'b1;
      expect_at(1, 1'b0, 1'b0, "R10");
      expect_at(2, 1'b0, 1'b0, "R10");
      tick(1);
      wdt_timeout = 1'b0; cfg_wr = 1'b0; cfg_route_rst = 1'b0;
      tick(2);

      // R4: release after the stabilization wait
      ext_rst_n = 1'b1;
      expect_at(STAB + 2, 1'b0, 1'b0, "R4");
      expect_at(STAB + 3, 1'b1, 1'b0, "R4");
      tick(STAB + 6);

      // R9: the write made in reset was dropped, so the timeout raises NMI
      wdt_timeout = 1'b1;
      expect_at(1, 1'b1, 1'b1, "R9");
      expect_at(2, 1'b1, 1'b0, "R9");
      tick(1);
      wdt_timeout = 1'b0;
      tick(4);

      // R3: two-cycle glitch is ignored
      ext_rst_n = 1'b0;
      expect_at(6, 1'b1, 1'b0, "R3");
      expect_at(8, 1'b1, 1'b0, "R3");
      tick(2);
      ext_rst_n = 1'b1;
      tick(10);

      // R7 and R8: held timeout gives one pulse
      wdt_timeout = 1'b1;
      expect_at(1, 1'b1, 1'b1, "R7");
      expect_at(2, 1'b1, 1'b0, "R8");
      expect_at(3, 1'b1, 1'b0, "R8");
      expect_at(4, 1'b1, 1'b0, "R8");
      tick(4);
      wdt_timeout = 1'b0;
      tick(3);

      // R6: routing bit set, timeout resets the chip
      cfg_wr = 1'b1; cfg_route_rst = 1'b1;
      tick(1);
      cfg_wr = 1'b0; cfg_route_rst = 1'b0;
      wdt_timeout = 1'b1;
      expect_at(1, 1'b0, 1'b0, "R6");
      expect_at(STAB, 1'b0, 1'b0, "R6");
      expect_at(STAB + 1, 1'b1, 1'b0, "R6");
      tick(1);
      wdt_timeout = 1'b0;
      tick(STAB + 3);

      // R9: the watchdog reset cleared the routing bit
      wdt_timeout = 1'b1;
      expect_at(1, 1'b1, 1'b1, "R9");
      tick(1);
      wdt_timeout = 1'b0;
      tick(4);

      // R2: three or more low samples assert reset
      ext_rst_n = 1'b0;
      expect_at(5, 1'b1, 1'b0, "R2");
      expect_at(6, 1'b0, 1'b0, "R2");
      tick(10);
      ext_rst_n = 1'b1;
      tick(10);

      // R5: glitch in the wait restarts the count
      ext_rst_n = 1'b0;
      expect_at(STAB - 6, 1'b0, 1'b0, "R5");
      expect_at(STAB + 3, 1'b0, 1'b0, "R5");
      expect_at(STAB + 4, 1'b1, 1'b0, "R5");
      tick(2);
      ext_rst_n = 1'b1;
      tick(STAB + 8);

      if (sb.size() != 0) begin
         errors = errors + 1;
         $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule